// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the low offset bits of a memory address over a four-beat burst. A burst opens when any of the address strobes is accepted. The strobed starting offset becomes the first address of the burst. From then on, each clock edge that samples the active-low advance input low moves the offset one step through a wrapping sequence. An edge that samples advance high keeps the burst where it is.

Two orders are supported. In linear order the offset counts up from the start and wraps modulo four. In interleaved order the offset is the start value with the running beat index folded in bitwise, so the sequence depends on which start offset was loaded. The order select input is a strap. It is expected to stay fixed while a burst runs.

The sequencer keeps two registers: the captured start offset and a beat index. The offset output is decoded from these two registers in the same cycle. After any clock edge, both outputs already reflect that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, before any load or advance, offset_o and beat_o are both 00.
- R2: When strobe_i bit 0 or strobe_i bit 1 is high at a rising edge, offset_o becomes start_i and beat_o becomes 00 after that edge.
- R3: With order_sel_i = 0 (linear), an advance (adv_n_i low, no strobe) at a rising edge makes offset_o equal to the previous offset plus one modulo four. For example, start 01 gives 01, 10, 11, 00.
- R4: With order_sel_i = 1 (interleaved), offset_o equals the loaded start XOR beat_o. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R5: When adv_n_i is high and no strobe is high at a rising edge, offset_o and beat_o keep their values (suspend).
- R6: Each advance increments beat_o by one modulo four. After four advances, offset_o is back at the loaded start in either order.
- R7: A strobe at the same edge as an advance performs the load only. offset_o becomes start_i and beat_o becomes 00.
- R8: Both strobe bits high together load exactly as a single strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 2 | Accepted address strobes, active high; any bit set loads a new burst |
| start_i | input | 2 | Starting offset captured on a load |
| adv_n_i | input | 1 | Active-low advance; low steps the burst, high suspends it |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| offset_o | output | 2 | Current low address offset |
| beat_o | output | 2 | Current beat index within the burst |

## Verification
Both registers drive offset_o combinationally. A corrupted start register or beat index is therefore visible on the ports immediately after the faulty edge. A beat index that skips or sticks shows on beat_o at once, and it also breaks the offset sequence in both orders. A start register that is lost or overwritten by an advance shows either as a wrong first offset after a load or as a failure to return to the start after four advances. A mixed-up order decode differs from the expected interleaved sequence at the second beat for any odd start offset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned DEF_OFS_W = 2;
  localparam int unsigned DEF_NUM_STB = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl #(
  parameter int unsigned NUM_STB = burst_seq_pkg::DEF_NUM_STB
) (
  input  logic [NUM_STB-1:0] strobe_i,
  input  logic               adv_n_i,
  output logic               load_evt_o,
  output logic               step_evt_o
);
  logic [NUM_STB:0] any_chain;

  assign any_chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign any_chain[g+1] = any_chain[g] | strobe_i[g];
  end

  assign load_evt_o = any_chain[NUM_STB];
  // a load wins over an advance in the same cycle
  assign step_evt_o = !adv_n_i && !load_evt_o;
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned OFS_W = burst_seq_pkg::DEF_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt_i,
  input  logic [OFS_W-1:0] start_i,
  output logic [OFS_W-1:0] start_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_q_o <= '0;
    else if (load_evt_i) start_q_o <= start_i;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned OFS_W = burst_seq_pkg::DEF_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt_i,
  input  logic             step_evt_i,
  output logic [OFS_W-1:0] beat_q_o
);
  function automatic logic [OFS_W-1:0] wrap_inc(input logic [OFS_W-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          beat_q_o <= '0;
    else if (load_evt_i) beat_q_o <= '0;
    else if (step_evt_i) beat_q_o <= wrap_inc(beat_q_o);
  end

  a_r6_beat_inc: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt_i |=> beat_q_o == $past(beat_q_o) + 1'b1);
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map #(
  parameter int unsigned OFS_W = burst_seq_pkg::DEF_OFS_W
) (
  input  logic [OFS_W-1:0] start_q_i,
  input  logic [OFS_W-1:0] beat_q_i,
  input  logic             order_sel_i,
  output logic [OFS_W-1:0] offset_o
);
  import burst_seq_pkg::*;

  function automatic logic [OFS_W-1:0] linear_ofs(input logic [OFS_W-1:0] s,
                                                  input logic [OFS_W-1:0] b);
    return s + b;
  endfunction

  function automatic logic [OFS_W-1:0] interleave_ofs(input logic [OFS_W-1:0] s,
                                                      input logic [OFS_W-1:0] b);
    return s ^ b;
  endfunction

  burst_order_e order;
  logic [OFS_W-1:0] lin_ofs, ilv_ofs;

  assign order   = burst_order_e'(order_sel_i);
  assign lin_ofs = linear_ofs(start_q_i, beat_q_i);
  assign ilv_ofs = interleave_ofs(start_q_i, beat_q_i);

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVE: offset_o = ilv_ofs;
      default:          offset_o = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned OFS_W   = burst_seq_pkg::DEF_OFS_W,
  parameter int unsigned NUM_STB = burst_seq_pkg::DEF_NUM_STB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_STB-1:0] strobe_i,
  input  logic [OFS_W-1:0]   start_i,
  input  logic               adv_n_i,
  input  logic               order_sel_i,
  output logic [OFS_W-1:0]   offset_o,
  output logic [OFS_W-1:0]   beat_o
);
  logic             load_evt;
  logic             step_evt;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;

  burst_load_ctrl #(.NUM_STB(NUM_STB)) u_load (
    .strobe_i   (strobe_i),
    .adv_n_i    (adv_n_i),
    .load_evt_o (load_evt),
    .step_evt_o (step_evt)
  );

  burst_start_reg #(.OFS_W(OFS_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt_i (load_evt),
    .start_i    (start_i),
    .start_q_o  (start_q)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt_i (load_evt),
    .step_evt_i (step_evt),
    .beat_q_o   (beat_q)
  );

  burst_offset_map #(.OFS_W(OFS_W)) u_map (
    .start_q_i   (start_q),
    .beat_q_i    (beat_q),
    .order_sel_i (order_sel_i),
    .offset_o    (offset_o)
  );

  assign beat_o = beat_q;

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (offset_o == '0 && beat_o == '0);
    end
  end

  // R2, R7, R8: any strobe loads the start and clears the beat
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe_i) |=> (offset_o == $past(start_i) && beat_o == '0));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|strobe_i) && !adv_n_i && !order_sel_i) |=>
      (order_sel_i || offset_o == $past(offset_o) + 1'b1));

  a_r4_interleave_link: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|strobe_i) && order_sel_i) |=>
      (!order_sel_i || $stable(offset_o ^ beat_o)));

  a_r5_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|strobe_i) && adv_n_i) |=>
      ((order_sel_i != $past(order_sel_i)) || ($stable(offset_o) && $stable(beat_o))));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strobe_i = 2'b00;
  logic [1:0] start_i = 2'b00;
  logic       adv_n_i = 1'b1;
  logic       order_sel_i = 1'b0;
  logic [1:0] offset_o;
  logic [1:0] beat_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe_i),
    .start_i     (start_i),
    .adv_n_i     (adv_n_i),
    .order_sel_i (order_sel_i),
    .offset_o    (offset_o),
    .beat_o      (beat_o)
  );

  // expected offsets restated from the requirements
  function automatic logic [1:0] exp_linear(input logic [1:0] s, input int k);
    return 2'((int'(s) + k) % 4);
  endfunction

  function automatic logic [1:0] exp_interleave(input logic [1:0] s, input int k);
    logic [1:0] kb = 2'(k % 4);
    return {s[1] != kb[1], s[0] != kb[0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [1:0] got, input logic [1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // drive at the falling edge, sample a quarter period after the rising edge
  task automatic cycle(input logic [1:0] stb, input logic [1:0] st,
                       input logic adv_n, input logic ord);
    @(negedge clk);
    strobe_i = stb; start_i = st; adv_n_i = adv_n; order_sel_i = ord;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", "offset in reset", offset_o, 2'b00);
    check("R1", "beat in reset", beat_o, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    cycle(2'b00, 2'b11, 1'b1, 1'b0);
    check("R1", "offset after reset", offset_o, 2'b00);
    check("R1", "beat after reset", beat_o, 2'b00);
  endtask

  task automatic t_load_each();
    cycle(2'b01, 2'b10, 1'b1, 1'b0);
    check("R2", "offset after strobe bit0", offset_o, 2'b10);
    check("R2", "beat after strobe bit0", beat_o, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 1'b0);
    cycle(2'b10, 2'b11, 1'b1, 1'b0);
    check("R2", "offset after strobe bit1", offset_o, 2'b11);
    check("R2", "beat after strobe bit1", beat_o, 2'b00);
  endtask

  task automatic t_linear(input logic [1:0] s);
    cycle(2'b01, s, 1'b1, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      cycle(2'b00, 2'b00, 1'b0, 1'b0);
      check("R3", $sformatf("linear start %b beat %0d", s, k), offset_o, exp_linear(s, k));
      check("R6", $sformatf("linear beat index %0d", k), beat_o, 2'(k % 4));
    end
    check("R6", "linear back at start", offset_o, s);
  endtask

  task automatic t_interleave(input logic [1:0] s);
    cycle(2'b10, s, 1'b1, 1'b1);
    check("R4", $sformatf("interleave first start %b", s), offset_o, s);
    for (int k = 1; k <= 4; k++) begin
      cycle(2'b00, 2'b00, 1'b0, 1'b1);
      check("R4", $sformatf("interleave start %b beat %0d", s, k), offset_o, exp_interleave(s, k));
    end
    check("R6", "interleave back at start", offset_o, s);
  endtask

  task automatic t_interleave_fixed();
    logic [1:0] seq01 [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    cycle(2'b01, 2'b01, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      check("R4", $sformatf("interleave 01 list %0d", k), offset_o, seq01[k]);
      cycle(2'b00, 2'b00, 1'b0, 1'b1);
    end
  endtask

  task automatic t_suspend();
    cycle(2'b01, 2'b01, 1'b1, 1'b0);
    cycle(2'b00, 2'b00, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cycle(2'b00, 2'b11, 1'b1, 1'b0);
      check("R5", "offset held while idle", offset_o, 2'b10);
      check("R5", "beat held while idle", beat_o, 2'b01);
    end
    cycle(2'b00, 2'b00, 1'b0, 1'b0);
    check("R5", "resume after suspend", offset_o, 2'b11);
  endtask

  task automatic t_load_priority();
    cycle(2'b01, 2'b00, 1'b1, 1'b1);
    cycle(2'b00, 2'b00, 1'b0, 1'b1);
    cycle(2'b00, 2'b00, 1'b0, 1'b1);
    cycle(2'b01, 2'b11, 1'b0, 1'b1);
    check("R7", "load beats advance offset", offset_o, 2'b11);
    check("R7", "load beats advance beat", beat_o, 2'b00);
  endtask

  task automatic t_both_strobes();
    cycle(2'b00, 2'b00, 1'b0, 1'b0);
    cycle(2'b11, 2'b10, 1'b1, 1'b0);
    check("R8", "both strobes offset", offset_o, 2'b10);
    check("R8", "both strobes beat", beat_o, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 1'b0);
    check("R8", "single step after dual load", offset_o, 2'b11);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_load_each();
    for (int s = 0; s < 4; s++) t_linear(2'(s));
    for (int s = 0; s < 4; s++) t_interleave(2'(s));
    t_interleave_fixed();
    t_suspend();
    t_load_priority();
    t_both_strobes();
    summary();
  end
endmodule